// File: doc/BRIEF.md
# Asynchronous SRAM Lane Controller

This block sits between a synchronous host and an asynchronous static RAM made of four byte-wide lanes. The lanes share one memory address and each has its own active-low chip select and write enable. A shared active-low output enable and a split data bus (outbound data with a drive enable, inbound data) complete the memory side. The host raises a request while the controller is ready. The request carries a read/write flag, a width mode and an address. The controller then plays out a fixed sequence of setup, strobe and recovery phases. The length of each phase in clock cycles is derived at elaboration time from nanosecond limits and the clock period, each limit rounded up to whole cycles.

The width mode is chosen per request. In word mode all four lanes take part. In halfword mode one adjacent lane pair is used, and in byte mode a single lane is used. The spare low host-address bits select the pair or the lane, and the remaining bits form the memory address. Narrow writes copy the host's low data bits onto the lanes being strobed. Narrow reads return the selected lanes in the low bits, zero-extended, together with a valid pulse one cycle wide.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, ready is high, all chip selects and write enables are high (inactive), output enable is high, the data drive enable is low and read-valid is low.
- R2: The lanes selected (chip select low) follow the mode code: code 0 (byte) selects lane number haddr[1:0] alone; code 1 (halfword) selects lanes 0 and 1 when haddr[0]=0 and lanes 2 and 3 when haddr[0]=1; codes 2 and 3 (word) select all four lanes.
- R3: The memory address is haddr[ADDR_W+1:2] in byte mode, haddr[ADDR_W:1] in halfword mode and haddr[ADDR_W-1:0] in word mode.
- R4: On a write, lane l (data bits 8l+7:8l) carries host byte l in word mode, host byte (l mod 2) in halfword mode and host byte 0 in byte mode. Lanes that are not selected keep their stored contents.
- R5: A read returns, zero-extended in the low bits, the selected lane in byte mode, the selected pair (lower-numbered lane in the low byte) in halfword mode and all four lanes in word mode.
- R6: A write lowers the write enable of exactly the selected lanes, only while their chip selects are low, in one pulse that lasts at least as many cycles as the longer of the write-pulse and data-setup limits.
- R7: The data drive enable is high, and output enable is high, in the cycle before any write enable falls. Output enable is never low while the drive enable is high.
- R8: On a read, all write enables stay high and output enable stays low long enough that chip select has been low for the address-access time. Read data is captured at the end of the strobe and read-valid is high for exactly one cycle.
- R9: Ready is low from the accepting clock edge until the recovery phase has ended, a total of 1 + strobe + recovery cycles covering at least the minimum cycle time. A request held high while busy starts no second access.
- R10: The memory address is set no later than the chip selects fall and stays constant while any chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host request, accepted when rdy is high |
| rdy | output | 1 | Controller idle and able to accept |
| wr | input | 1 | 1 = write, 0 = read |
| mode | input | 2 | Width code: 0 byte, 1 halfword, 2 or 3 word |
| haddr | input | ADDR_W+2 | Host address including lane-select bits |
| wdata | input | 4*LANE_W | Host write data |
| rdata | output | 4*LANE_W | Read data, zero-extended in narrow modes |
| rvalid | output | 1 | One-cycle pulse when rdata is new |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 4*LANE_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 4*LANE_W | Data returned by the memory |

## Verification
The memory is first filled with full-word writes. It is then overwritten piecewise with halfword writes into both pairs and byte writes into every lane, so that a wrong lane mask or a wrong byte copy leaves a wrong value where the later reads will find it. Each word is then read back in all three widths and at every pair and lane offset, which separates errors in lane selection, in address shifting and in zero extension. A bench memory model returns garbage when the strobe is shorter than the access time, when data is not driven, or when a read is taken at the wrong edge. Accesses with the top address bits set, the alternate word code, and a request held high through the busy period cover the remaining boundaries.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  localparam int NLANES = 4;

  localparam logic [1:0] MODE_BYTE = 2'd0;
  localparam logic [1:0] MODE_HALF = 2'd1;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETUP  = 2'd1,
    S_STROBE = 2'd2,
    S_RECOV  = 2'd3
  } seq_state_t;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int cyc_ceil(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Write strobe: long enough for the pulse width and for the data setup.
  function automatic int wp_cycles(input int clk_ns, input int wp_ns, input int dw_ns);
    return imax(1, imax(cyc_ceil(wp_ns, clk_ns), cyc_ceil(dw_ns, clk_ns)));
  endfunction

  // Read strobe: output-enable access, and address access less the setup cycle.
  function automatic int rd_cycles(input int clk_ns, input int oe_ns, input int aa_ns);
    return imax(1, imax(cyc_ceil(oe_ns, clk_ns), cyc_ceil(aa_ns, clk_ns) - 1));
  endfunction

  // Recovery: at least one idle-strobe cycle, padded up to the cycle time.
  function automatic int rec_cycles(input int clk_ns, input int rc_ns,
                                    input int n_wp, input int n_rd);
    return imax(1, cyc_ceil(rc_ns, clk_ns) - 1 - imin(n_wp, n_rd));
  endfunction

  function automatic logic [NLANES-1:0] lane_mask(input logic [1:0] mode,
                                                  input logic [1:0] sel);
    logic [NLANES-1:0] m;
    case (mode)
      MODE_BYTE: m = 4'(4'b0001 << sel);
      MODE_HALF: m = sel[0] ? 4'b1100 : 4'b0011;
      default:   m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode
  import sram_lane_pkg::*;
#(
  parameter int AW = 19,
  parameter int LW = 8
) (
  input  logic [1:0]           mode,
  input  logic [AW+1:0]        haddr,
  input  logic [NLANES*LW-1:0] wdata,
  output logic [NLANES-1:0]    mask,
  output logic [AW-1:0]        maddr,
  output logic [NLANES*LW-1:0] lane_wd
);

  assign mask = lane_mask(mode, haddr[1:0]);

  always_comb begin
    case (mode)
      MODE_BYTE: maddr = haddr[AW+1:2];
      MODE_HALF: maddr = haddr[AW:1];
      default:   maddr = haddr[AW-1:0];
    endcase
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign lane_wd[l*LW +: LW] =
      (mode == MODE_BYTE) ? wdata[LW-1:0] :
      (mode == MODE_HALF) ? wdata[(l % 2)*LW +: LW] :
                            wdata[l*LW +: LW];
  end

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int AW    = 19,
  parameter int DW    = 32,
  parameter int N_WP  = 4,
  parameter int N_RD  = 4,
  parameter int N_REC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr,
  input  logic [NLANES-1:0] mask_in,
  input  logic [AW-1:0]     maddr_in,
  input  logic [DW-1:0]     wd_in,
  output logic              idle,
  output logic              sample,
  output logic              we_arm,
  output logic [AW-1:0]     mem_addr,
  output logic [NLANES-1:0] cs_n,
  output logic [NLANES-1:0] we_n,
  output logic              oe_n,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe
);

  localparam int CNT_MAX = imax(imax(N_WP, N_RD), N_REC);
  localparam int CW      = $clog2(CNT_MAX + 1);

  seq_state_t        st;
  logic [CW-1:0]     cnt;
  logic              op_wr;
  logic [NLANES-1:0] mask_q;
  logic              cnt_done;

  assign cnt_done = (cnt == '0);
  assign idle     = (st == S_IDLE);
  assign sample   = (st == S_STROBE) && cnt_done && !op_wr;
  assign we_arm   = (st == S_SETUP) && op_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      op_wr    <= 1'b0;
      mask_q   <= '0;
      mem_addr <= '0;
      cs_n     <= '1;
      we_n     <= '1;
      oe_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            st       <= S_SETUP;
            op_wr    <= wr;
            mask_q   <= mask_in;
            mem_addr <= maddr_in;
            dq_out   <= wd_in;
            cs_n     <= ~mask_in;
            dq_oe    <= wr;
          end
        end
        S_SETUP: begin
          st <= S_STROBE;
          if (op_wr) begin
            cnt  <= CW'(N_WP - 1);
            we_n <= ~mask_q;
          end else begin
            cnt  <= CW'(N_RD - 1);
            oe_n <= 1'b0;
          end
        end
        S_STROBE: begin
          if (cnt_done) begin
            st    <= S_RECOV;
            cnt   <= CW'(N_REC - 1);
            we_n  <= '1;
            oe_n  <= 1'b1;
            cs_n  <= '1;
            dq_oe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_rdata.sv
module sram_lane_rdata
  import sram_lane_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [1:0]           mode,
  input  logic [1:0]           sel,
  input  logic                 sample,
  input  logic [NLANES*LW-1:0] dq_in,
  output logic [NLANES*LW-1:0] rdata,
  output logic                 rvalid
);

  localparam int DW = NLANES * LW;

  logic [1:0]    mode_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    case (mode_q)
      MODE_BYTE: pick[LW-1:0]   = dq_in[int'(sel_q)*LW +: LW];
      MODE_HALF: pick[2*LW-1:0] = sel_q[0] ? dq_in[DW-1:2*LW] : dq_in[2*LW-1:0];
      default:   pick           = dq_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (accept) begin
        mode_q <= mode;
        sel_q  <= sel;
      end
      rvalid <= sample;
      if (sample) rdata <= pick;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int LANE_W  = 8,
  parameter int CLK_NS  = 4,
  parameter int T_WP_NS = 15,
  parameter int T_DW_NS = 10,
  parameter int T_RC_NS = 20,
  parameter int T_AA_NS = 20,
  parameter int T_OE_NS = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  output logic                     rdy,
  input  logic                     wr,
  input  logic [1:0]               mode,
  input  logic [ADDR_W+1:0]        haddr,
  input  logic [NLANES*LANE_W-1:0] wdata,
  output logic [NLANES*LANE_W-1:0] rdata,
  output logic                     rvalid,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [NLANES-1:0]        mem_cs_n,
  output logic [NLANES-1:0]        mem_we_n,
  output logic                     mem_oe_n,
  output logic [NLANES*LANE_W-1:0] mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [NLANES*LANE_W-1:0] mem_dq_in
);

  localparam int DW    = NLANES * LANE_W;
  localparam int N_WP  = wp_cycles(CLK_NS, T_WP_NS, T_DW_NS);
  localparam int N_RD  = rd_cycles(CLK_NS, T_OE_NS, T_AA_NS);
  localparam int N_REC = rec_cycles(CLK_NS, T_RC_NS, N_WP, N_RD);

  // Named internal events, observed by the bound checker.
  logic              ev_accept;
  logic              ev_sample;
  logic              ev_we_arm;
  logic [NLANES-1:0] dec_mask;
  logic [ADDR_W-1:0] dec_addr;
  logic [DW-1:0]     dec_wd;

  assign ev_accept = req && rdy;

  sram_lane_decode #(.AW(ADDR_W), .LW(LANE_W)) i_decode (
    .mode    (mode),
    .haddr   (haddr),
    .wdata   (wdata),
    .mask    (dec_mask),
    .maddr   (dec_addr),
    .lane_wd (dec_wd)
  );

  sram_lane_seq #(
    .AW(ADDR_W), .DW(DW), .N_WP(N_WP), .N_RD(N_RD), .N_REC(N_REC)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (ev_accept),
    .wr       (wr),
    .mask_in  (dec_mask),
    .maddr_in (dec_addr),
    .wd_in    (dec_wd),
    .idle     (rdy),
    .sample   (ev_sample),
    .we_arm   (ev_we_arm),
    .mem_addr (mem_addr),
    .cs_n     (mem_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_out   (mem_dq_out),
    .dq_oe    (mem_dq_oe)
  );

  sram_lane_rdata #(.LW(LANE_W)) i_rdata (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (ev_accept),
    .mode   (mode),
    .sel    (haddr[1:0]),
    .sample (ev_sample),
    .dq_in  (mem_dq_in),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW   = 19,
  parameter int N_WP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy,
  input logic          rvalid,
  input logic [3:0]    cs_n,
  input logic [3:0]    we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic [AW-1:0] addr,
  input logic          ev_accept,
  input logic          ev_we_arm
);

  logic [7:0] we_run;
  logic       we_any;
  logic       cs_any;

  assign we_any = |(~we_n);
  assign cs_any = |(~cs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       we_run <= '0;
    else if (we_any)  we_run <= (we_run == 8'hFF) ? we_run : we_run + 8'd1;
    else              we_run <= '0;
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~we_n) & cs_n) == 4'b0000);                                      // R6
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_any) && !we_any) |-> (int'(we_run) >= N_WP));            // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));                                                // R7
  AST_DRIVE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&we_n) |-> ($past(dq_oe) && $past(oe_n) && $past(ev_we_arm))); // R7
  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (&we_n));                                                // R8
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);                                               // R8
  AST_BUSY_WHILE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_any |-> !rdy);                                                  // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !rdy);                                               // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_any && $past(cs_any)) |-> $stable(addr));                      // R10
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n inside {4'hF, 4'hE, 4'hD, 4'hB, 4'h7, 4'hC, 4'h3, 4'h0});     // R2

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(ADDR_W), .N_WP(N_WP)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy       (rdy),
  .rvalid    (rvalid),
  .cs_n      (mem_cs_n),
  .we_n      (mem_we_n),
  .oe_n      (mem_oe_n),
  .dq_oe     (mem_dq_oe),
  .addr      (mem_addr),
  .ev_accept (ev_accept),
  .ev_we_arm (ev_we_arm)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  localparam int CLK = 4;

  // Smallest cycle count k with k*CLK >= ns.
  function automatic int cover_ns(input int ns);
    int k = 0;
    while (k * CLK < ns) k++;
    return k;
  endfunction

  localparam int E_WP   = (cover_ns(15) > cover_ns(10)) ? cover_ns(15) : cover_ns(10);
  localparam int E_RD   = (cover_ns(10) > cover_ns(20) - 1) ? cover_ns(10) : cover_ns(20) - 1;
  localparam int E_MINS = (E_WP < E_RD) ? E_WP : E_RD;
  localparam int E_REC  = (cover_ns(20) - 1 - E_MINS > 1) ? cover_ns(20) - 1 - E_MINS : 1;
  localparam int E_BUSY_W = 1 + E_WP + E_REC;
  localparam int E_BUSY_R = 1 + E_RD + E_REC;
  localparam int ACC_CS = cover_ns(20);
  localparam int ACC_OE = cover_ns(10);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  mode = 2'd2;
  logic [20:0] haddr = '0;
  logic [31:0] wdata = '0;
  logic        rdy, rvalid, mem_oe_n, mem_dq_oe;
  logic [31:0] rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_we_n;

  always #2 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .rdy(rdy), .wr(wr), .mode(mode),
    .haddr(haddr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Memory model: 4 lanes x 64 words, indexed by the low address bits.
  logic [7:0] mem_l [4][64];
  logic [7:0] sh    [4][64];
  int cs_age = 0, oe_age = 0;

  always @(negedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!mem_cs_n[l] && !mem_we_n[l])
        mem_l[l][mem_addr[5:0]] <= mem_dq_oe ? mem_dq_out[l*8 +: 8] : 8'h5A;
    cs_age <= (|(~mem_cs_n)) ? cs_age + 1 : 0;
    oe_age <= (!mem_oe_n) ? oe_age + 1 : 0;
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      mem_dq_in[l*8 +: 8] = (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l] &&
                             cs_age >= ACC_CS && oe_age >= ACC_OE)
                            ? mem_l[l][mem_addr[5:0]] : 8'hA5;
  end

  // Monitor of the memory-side sequence.
  logic        prev_cs_any = 1'b0, prev_we_any = 1'b0, prev_dq_oe = 1'b0, prev_rdy = 1'b1;
  logic [18:0] cap_addr = '0;
  logic [3:0]  cap_mask = '0;
  int cs_falls = 0, we_run = 0, last_we = 0, busy_run = 0, last_busy = 0;
  int late_cnt = 0, cont_cnt = 0, rv_cnt = 0;
  logic [31:0] rv_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((|(~mem_cs_n)) && !prev_cs_any) begin
        cap_addr <= mem_addr;
        cap_mask <= ~mem_cs_n;
        cs_falls <= cs_falls + 1;
      end
      if (|(~mem_we_n)) we_run <= we_run + 1;
      else if (prev_we_any) begin last_we <= we_run; we_run <= 0; end
      if ((|(~mem_we_n)) && !prev_we_any && !(prev_dq_oe && mem_dq_oe)) late_cnt <= late_cnt + 1;
      if (mem_dq_oe && !mem_oe_n) cont_cnt <= cont_cnt + 1;
      if (!rdy) busy_run <= busy_run + 1;
      else if (!prev_rdy) begin last_busy <= busy_run; busy_run <= 0; end
      if (rvalid) begin rv_cnt <= rv_cnt + 1; rv_data <= rdata; end
      prev_cs_any <= |(~mem_cs_n);
      prev_we_any <= |(~mem_we_n);
      prev_dq_oe  <= mem_dq_oe;
      prev_rdy    <= rdy;
    end
  end

  int errs = 0, checks = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] e_mask(input logic [1:0] m, input logic [20:0] h);
    if (m == 2'd0) return 4'(1 << h[1:0]);
    if (m == 2'd1) return h[0] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [18:0] e_addr(input logic [1:0] m, input logic [20:0] h);
    if (m == 2'd0) return 19'(h / 4);
    if (m == 2'd1) return 19'(h / 2);
    return 19'(h);
  endfunction

  task automatic txn(input logic w, input logic [1:0] m, input logic [20:0] h,
                     input logic [31:0] d, input int hold);
    int f0, r0, lo;
    logic [3:0]  em;
    logic [18:0] ea;
    logic [31:0] ex;
    f0 = cs_falls; r0 = rv_cnt;
    em = e_mask(m, h); ea = e_addr(m, h);
    @(negedge clk); #1;
    req = 1'b1; wr = w; mode = m; haddr = h; wdata = d;
    repeat (hold) begin @(negedge clk); #1; end
    req = 1'b0;
    do begin @(negedge clk); #1; end while (!rdy);
    @(negedge clk); #1;
    chk("R3 address", 64'(cap_addr), 64'(ea));
    chk("R2 lane mask", 64'(cap_mask), 64'(em));
    chk("R9 one access per request", 64'(cs_falls - f0), 64'd1);
    if (w) begin
      chk("R9 write busy cycles", 64'(last_busy), 64'(E_BUSY_W));
      chk("R6 write pulse cycles", 64'(last_we), 64'(E_WP));
      for (int l = 0; l < 4; l++)
        if (em[l]) begin
          lo = (m == 2'd0) ? 0 : (m == 2'd1) ? (l % 2) : l;
          sh[l][ea[5:0]] = d[lo*8 +: 8];
        end
    end else begin
      chk("R9 read busy cycles", 64'(last_busy), 64'(E_BUSY_R));
      chk("R8 rvalid single pulse", 64'(rv_cnt - r0), 64'd1);
      if (m == 2'd0)      ex = {24'd0, sh[h[1:0]][ea[5:0]]};
      else if (m == 2'd1) ex = {16'd0, sh[2*h[0]+1][ea[5:0]], sh[2*h[0]][ea[5:0]]};
      else                ex = {sh[3][ea[5:0]], sh[2][ea[5:0]], sh[1][ea[5:0]], sh[0][ea[5:0]]};
      chk("R5 read data", 64'(rv_data), 64'(ex));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R9 watchdog: got busy expected done");
    finish_run();
  end

  initial begin
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < 64; a++) begin mem_l[l][a] = 8'h00; sh[l][a] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 rdy", 64'(rdy), 64'd1);
    chk("R1 cs_n", 64'(mem_cs_n), 64'hF);
    chk("R1 we_n", 64'(mem_we_n), 64'hF);
    chk("R1 oe_n", 64'(mem_oe_n), 64'd1);
    chk("R1 dq_oe", 64'(mem_dq_oe), 64'd0);
    chk("R1 rvalid", 64'(rvalid), 64'd0);

    // R4 word fill
    for (int w = 0; w < 16; w++)
      txn(1'b1, 2'd2, 21'(w), 32'hA000_0000 ^ (32'(w) * 32'h0103_0507), 1);
    // R4 halfword writes into both pairs, junk in upper bits
    for (int w = 0; w < 8; w++)
      for (int p = 0; p < 2; p++)
        txn(1'b1, 2'd1, 21'(w*2 + p), {16'hDEAD, 16'hC000 + 16'(w*16 + p)}, 1);
    // R4 byte writes into every lane, junk in upper bits
    for (int w = 8; w < 16; w++)
      for (int l = 0; l < 4; l++)
        txn(1'b1, 2'd0, 21'(w*4 + l), {24'hBEEF77, 8'h40 + 8'(w*4 + l)}, 1);
    // R5 read back at every width and offset
    for (int w = 0; w < 16; w++) txn(1'b0, 2'd2, 21'(w), 32'h0, 1);
    for (int w = 0; w < 16; w++)
      for (int p = 0; p < 2; p++) txn(1'b0, 2'd1, 21'(w*2 + p), 32'h0, 1);
    for (int w = 0; w < 16; w++)
      for (int l = 0; l < 4; l++) txn(1'b0, 2'd0, 21'(w*4 + l), 32'h0, 1);
    // R3 top address bits, R2 alternate word code
    txn(1'b1, 2'd0, 21'h1FFFFE, 32'h0000_0077, 1);
    txn(1'b0, 2'd3, 21'h07FF3F, 32'h0, 1);
    txn(1'b1, 2'd3, 21'h1C0005, 32'h1234_5678, 1);
    txn(1'b0, 2'd1, 21'h00000B, 32'h0, 1);
    // R9 request held high while busy
    txn(1'b1, 2'd2, 21'd20, 32'hFACE_B00C, 3);
    txn(1'b0, 2'd2, 21'd20, 32'h0, 1);
    // R7 drive-enable ordering and no contention, counted over the run
    chk("R7 drive before write enable", 64'(late_cnt), 64'd0);
    chk("R7 no output contention", 64'(cont_cnt), 64'd0);
    finish_run();
  end

endmodule